// File: doc/BRIEF.md
# Storage-Key Reference and Change Recorder

This block holds one storage key per page of absolute memory and updates it as translated accesses go by. Each accepted access carries an absolute address, an access kind (load, store or instruction fetch), the permission flags that translation produced, and a global bit saying whether storage keys are in use yet. The block sets the reference bit on any access and the change bit on stores. It returns the flags, with write permission withheld when a load or fetch touches a page whose change bit is still clear. That way, a later store to the page misses and comes back through the block, which then sets the change bit.

The key update is a two-cycle read-modify-write. The key is read when the access is captured, and the new key is computed and written back one cycle later, but only if it differs from the old one. A back-to-back access to the same page sees the pending result through forwarding. A separate maintenance port reads and writes keys directly. Its writes override a same-cycle update to the same page and are forwarded to an access captured in that cycle. Key-controlled protection, meaning matching an access key against the stored one, is not performed.

Top module: `skey_ref_change`

## Requirements
- R1: When keys_en is 0 at capture, the access leaves its page's key unchanged and rsp_flags equals acc_flags, even for a load of a page whose change bit is clear.
- R2: The key for an access is selected by page number modulo NUM_PAGES, that is acc_addr[PAGE_BITS +: IDX_W]. The offset bits within the page and the address bits above the index play no part.
- R3: Flag bits are read = bit 0, write = bit 1, exec = bit 2. With keys enabled, a load or fetch of a page whose change bit is 0 returns acc_flags with bit 1 cleared. If the change bit is 1, acc_flags is returned unchanged.
- R4: With keys enabled, a store sets the change bit (key bit 0) and returns acc_flags unchanged.
- R5: Key layout: bits 6:3 are the access key, bit 2 is fetch-protect, bit 1 is reference, bit 0 is change. Any enabled load, store or fetch sets bit 1 and leaves bits 6:2 as they were.
- R6: The key store is written by the update path only when the new key differs from the old one. An access that alters nothing leaves the key as it was.
- R7: An access presented with acc_valid=1 before clock edge k gives rsp_valid=1 with its rsp_flags after edge k+1, and at no other time.
- R8: An access to the same page in the cycle directly after another sees that earlier access's key update. A load right after a store to the same page therefore keeps write permission.
- R9: A maintenance write (host_valid=1, host_we=1) wins over an update-path write to the same page at the same edge. It is also seen by an access to that page captured at that edge.
- R10: A maintenance read (host_valid=1, host_we=0) returns host_rvalid=1 and the page's key on host_rkey after the next clock edge.
- R11: acc_type codes are 00 load, 01 store, 10 fetch and 11 no-op. A no-op still gives a response with rsp_flags equal to acc_flags and leaves the key unchanged.
- R12: After reset, every key is 0 and rsp_valid and host_rvalid are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| keys_en | input | 1 | Storage keys in use; sampled with the access |
| acc_valid | input | 1 | Access present this cycle |
| acc_type | input | 2 | 00 load, 01 store, 10 fetch, 11 no-op |
| acc_addr | input | ADDR_W | Absolute address of the access |
| acc_flags | input | 3 | Permission flags from translation (read, write, exec) |
| rsp_valid | output | 1 | Response flags valid |
| rsp_flags | output | 3 | Flags after key handling |
| host_valid | input | 1 | Maintenance request present |
| host_we | input | 1 | Maintenance request is a write |
| host_page | input | IDX_W | Page index for the maintenance request |
| host_wkey | input | 7 | Key to write |
| host_rvalid | output | 1 | Maintenance read data valid |
| host_rkey | output | 7 | Key read by the maintenance port |

## Verification
A stale or lost key update shows up in two ways. The next load of that page returns the wrong write flag two cycles after it is presented, and a maintenance read shows the wrong key one cycle after it is requested. A missing forward shows only when accesses to one page are back to back, so the directed cases pair store-then-load and host-write-with-access in adjacent cycles. A wrong priority between the two write sources leaves the host's key overwritten. That appears on the first maintenance read after the collision.

// File: rtl/skey_pkg.sv
// Package: shared key layout, flag positions and access kinds for the
// storage-key recorder. Assumes the 7-bit key layout stated in the brief.
package skey_pkg;
    localparam int KEY_W      = 7;
    localparam int CHG_BIT    = 0;
    localparam int REF_BIT    = 1;
    localparam int FP_BIT     = 2;
    localparam int ACCKEY_LSB = 3;

    localparam int FLAG_W = 3;
    localparam int FLG_RD = 0;
    localparam int FLG_WR = 1;
    localparam int FLG_EX = 2;

    typedef logic [KEY_W-1:0]  skey_t;
    typedef logic [FLAG_W-1:0] pflags_t;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_NONE  = 2'b11
    } acc_kind_e;
endpackage

// File: rtl/skey_store.sv
// Module: per-page key storage with two combinational read ports and two
// write ports. The maintenance write has priority over the update write when
// both target the same page. Assumes NUM_PAGES is a power of two.
module skey_store
    import skey_pkg::*;
#(
    parameter int NUM_PAGES = 64,
    parameter int IDX_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    output skey_t            rd_a_key,
    input  logic [IDX_W-1:0] rd_b_idx,
    output skey_t            rd_b_key,
    input  logic             hw_we,
    input  logic [IDX_W-1:0] hw_idx,
    input  skey_t            hw_key,
    input  logic             uw_we,
    input  logic [IDX_W-1:0] uw_idx,
    input  skey_t            uw_key
);
    skey_t mem [NUM_PAGES];

    // One register per page: reset, then host write, then update write.
    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (hw_we && hw_idx == IDX_W'(g)) begin
                mem[g] <= hw_key;
            end else if (uw_we && uw_idx == IDX_W'(g)) begin
                mem[g] <= uw_key;
            end
        end
    end

    // Read ports: current stored value, no bypass.
    assign rd_a_key = mem[rd_a_idx];
    assign rd_b_key = mem[rd_b_idx];

    // R9: colliding writes leave the maintenance value in place.
    a_r9_host_over_update: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_we && uw_we && hw_idx == uw_idx) |=> mem[$past(hw_idx)] == $past(hw_key));

    // R6: an uncontested update write lands in its entry.
    a_r6_update_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (uw_we && !(hw_we && hw_idx == uw_idx)) |=> mem[$past(uw_idx)] == $past(uw_key));
endmodule

// File: rtl/skey_rmw.sv
// Module: combinational key modification and flag filtering for one access.
// Assumes old_key already reflects any forwarded pending write.
module skey_rmw
    import skey_pkg::*;
(
    input  logic      en,
    input  acc_kind_e kind,
    input  skey_t     old_key,
    input  pflags_t   flags_in,
    output skey_t     new_key,
    output logic      key_we,
    output pflags_t   flags_out
);
    logic is_read_kind;
    logic is_store;
    logic counts;

    // Classify the access.
    always_comb begin
        is_read_kind = (kind == ACC_LOAD) || (kind == ACC_FETCH);
        is_store     = (kind == ACC_STORE);
        counts       = en && (is_read_kind || is_store);
    end

    // Next key value: reference on any counted access, change on stores.
    always_comb begin
        new_key = old_key;
        if (counts) begin
            new_key[REF_BIT] = 1'b1;
            if (is_store) begin
                new_key[CHG_BIT] = 1'b1;
            end
        end
        key_we = counts && (new_key != old_key);
    end

    // Flag filter: hold back write permission on reads of unchanged pages.
    always_comb begin
        flags_out = flags_in;
        if (en && is_read_kind && !old_key[CHG_BIT]) begin
            flags_out[FLG_WR] = 1'b0;
        end
    end
endmodule

// File: rtl/skey_hostrd.sv
// Module: registered read side of the maintenance port. Presents the page
// index to the store and registers the key one cycle later.
module skey_hostrd
    import skey_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic [IDX_W-1:0] rd_page,
    output logic [IDX_W-1:0] mem_idx,
    input  skey_t            mem_key,
    output logic             rvalid,
    output skey_t            rkey
);
    assign mem_idx = rd_page;

    // Capture the stored key on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rkey   <= '0;
        end else begin
            rvalid <= rd_req;
            if (rd_req) begin
                rkey <= mem_key;
            end
        end
    end

    // R10: a read request is answered at the next edge.
    a_r10_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rvalid);
    a_r10_no_spurious_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rvalid);
endmodule

// File: rtl/skey_ref_change.sv
// Module: top of the storage-key reference/change recorder. Captures each
// access with its key (forwarded from pending writes), then updates the key
// and returns filtered flags one cycle later. Assumes addresses were already
// validated and that the maintenance port may act in any cycle.
module skey_ref_change
    import skey_pkg::*;
#(
    parameter  int ADDR_W    = 32,
    parameter  int PAGE_BITS = 12,
    parameter  int NUM_PAGES = 64,
    localparam int IDX_W     = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              keys_en,
    input  logic              acc_valid,
    input  logic [1:0]        acc_type,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [2:0]        acc_flags,
    output logic              rsp_valid,
    output logic [2:0]        rsp_flags,
    input  logic              host_valid,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_page,
    input  logic [6:0]        host_wkey,
    output logic              host_rvalid,
    output logic [6:0]        host_rkey
);
    logic             unused_addr_bits;
    logic [IDX_W-1:0] acc_idx;
    logic             host_wr;
    logic             host_rd;
    logic [IDX_W-1:0] hostrd_idx;
    skey_t            hostrd_key;
    skey_t            acc_rd_key;
    skey_t            cap_key;

    logic             s1_valid;
    logic             s1_en;
    acc_kind_e        s1_kind;
    logic [IDX_W-1:0] s1_idx;
    pflags_t          s1_flags;
    skey_t            s1_key;

    skey_t            upd_key;
    logic             upd_we;
    pflags_t          upd_flags;

    // Page index from the absolute address; other bits are not needed.
    assign acc_idx          = acc_addr[PAGE_BITS +: IDX_W];
    assign unused_addr_bits = ^acc_addr;
    assign host_wr          = host_valid && host_we;
    assign host_rd          = host_valid && !host_we;

    skey_store #(.NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (acc_idx),
        .rd_a_key (acc_rd_key),
        .rd_b_idx (hostrd_idx),
        .rd_b_key (hostrd_key),
        .hw_we    (host_wr),
        .hw_idx   (host_page),
        .hw_key   (host_wkey),
        .uw_we    (upd_we),
        .uw_idx   (s1_idx),
        .uw_key   (upd_key)
    );

    skey_hostrd #(.IDX_W(IDX_W)) u_hostrd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (host_rd),
        .rd_page (host_page),
        .mem_idx (hostrd_idx),
        .mem_key (hostrd_key),
        .rvalid  (host_rvalid),
        .rkey    (host_rkey)
    );

    // Key seen at capture: host write first, then the pending update, then storage.
    always_comb begin
        if (host_wr && host_page == acc_idx) begin
            cap_key = host_wkey;
        end else if (upd_we && s1_idx == acc_idx) begin
            cap_key = upd_key;
        end else begin
            cap_key = acc_rd_key;
        end
    end

    // Capture stage: hold the access and its key for the update cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_en    <= 1'b0;
            s1_kind  <= ACC_NONE;
            s1_idx   <= '0;
            s1_flags <= '0;
            s1_key   <= '0;
        end else begin
            s1_valid <= acc_valid;
            if (acc_valid) begin
                s1_en    <= keys_en;
                s1_kind  <= acc_kind_e'(acc_type);
                s1_idx   <= acc_idx;
                s1_flags <= acc_flags;
                s1_key   <= cap_key;
            end
        end
    end

    skey_rmw u_rmw (
        .en        (s1_valid && s1_en),
        .kind      (s1_kind),
        .old_key   (s1_key),
        .flags_in  (s1_flags),
        .new_key   (upd_key),
        .key_we    (upd_we),
        .flags_out (upd_flags)
    );

    // Response stage: register the filtered flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_flags <= '0;
        end else begin
            rsp_valid <= s1_valid;
            if (s1_valid) begin
                rsp_flags <= upd_flags;
            end
        end
    end

    // R1: a disabled access never writes a key.
    a_r1_off_no_keywrite: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_en) |-> !upd_we);
    // R1: a disabled access returns its flags as given.
    a_r1_off_flags_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_en) |=> rsp_flags == $past(s1_flags));
    // R3: a read of a page with change clear loses write permission.
    a_r3_read_clean_no_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_en && (s1_kind == ACC_LOAD || s1_kind == ACC_FETCH)
         && !s1_key[CHG_BIT]) |=> !rsp_flags[FLG_WR]);
    // R4: a store returns its flags as given.
    a_r4_store_flags_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_en && s1_kind == ACC_STORE) |=> rsp_flags == $past(s1_flags));
    // R5: a written key always carries the reference bit and old upper fields.
    a_r5_ref_set_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        upd_we |-> (upd_key[REF_BIT] && upd_key[KEY_W-1:FP_BIT] == s1_key[KEY_W-1:FP_BIT]));
    // R6: no write-back of an unchanged key.
    a_r6_no_redundant_write: assert property (@(posedge clk) disable iff (!rst_n)
        upd_we |-> (upd_key != s1_key));
    // R7: two-stage latency, one response per access.
    a_r7_capture_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> s1_valid);
    a_r7_response_follows: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> rsp_valid);
    a_r7_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> !rsp_valid);
endmodule

// File: tb/skey_ref_change_test.sv
`timescale 1ns/1ps
module skey_ref_change_test;
    localparam int ADDR_W    = 32;
    localparam int PAGE_BITS = 12;
    localparam int NUM_PAGES = 64;
    localparam int IDX_W     = 6;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              keys_en;
    logic              acc_valid;
    logic [1:0]        acc_type;
    logic [ADDR_W-1:0] acc_addr;
    logic [2:0]        acc_flags;
    logic              rsp_valid;
    logic [2:0]        rsp_flags;
    logic              host_valid;
    logic              host_we;
    logic [IDX_W-1:0]  host_page;
    logic [6:0]        host_wkey;
    logic              host_rvalid;
    logic [6:0]        host_rkey;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    localparam logic [1:0] T_LOAD = 2'b00, T_STORE = 2'b01, T_FETCH = 2'b10, T_NONE = 2'b11;

    always #4 clk = ~clk;

    skey_ref_change #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .NUM_PAGES(NUM_PAGES)) uut (
        .clk(clk), .rst_n(rst_n), .keys_en(keys_en),
        .acc_valid(acc_valid), .acc_type(acc_type), .acc_addr(acc_addr), .acc_flags(acc_flags),
        .rsp_valid(rsp_valid), .rsp_flags(rsp_flags),
        .host_valid(host_valid), .host_we(host_we), .host_page(host_page), .host_wkey(host_wkey),
        .host_rvalid(host_rvalid), .host_rkey(host_rkey)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] page_addr(input int page, input int offs);
        return ADDR_W'(page) << PAGE_BITS | ADDR_W'(offs);
    endfunction

    task automatic drive_acc(input logic [1:0] t, input logic [ADDR_W-1:0] a, input logic [2:0] f, input logic en);
        acc_valid = 1'b1; acc_type = t; acc_addr = a; acc_flags = f; keys_en = en;
    endtask

    task automatic idle_acc();
        acc_valid = 1'b0; acc_type = T_NONE; acc_addr = '0; acc_flags = '0;
    endtask

    // Single access with latency check (R7) and flag check.
    task automatic access(input string req, input logic [1:0] t, input logic [ADDR_W-1:0] a,
                          input logic [2:0] f, input logic en, input logic [2:0] exp_flags);
        @(negedge clk); drive_acc(t, a, f, en);
        @(posedge clk);
        @(negedge clk); idle_acc();
        check("R7", "rsp_valid one edge after capture", rsp_valid, 0);
        @(posedge clk);
        @(negedge clk);
        check("R7", "rsp_valid two edges after capture", rsp_valid, 1);
        check(req, "rsp_flags", rsp_flags, exp_flags);
    endtask

    task automatic host_write(input int page, input logic [6:0] k);
        @(negedge clk); host_valid = 1'b1; host_we = 1'b1; host_page = IDX_W'(page); host_wkey = k;
        @(posedge clk);
        @(negedge clk); host_valid = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_read(input string req, input int page, input logic [6:0] exp);
        @(negedge clk); host_valid = 1'b1; host_we = 1'b0; host_page = IDX_W'(page);
        @(posedge clk);
        @(negedge clk); host_valid = 1'b0;
        check("R10", "host_rvalid", host_rvalid, 1);
        check(req, $sformatf("key of page %0d", page), host_rkey, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R12", "rsp_valid after reset", rsp_valid, 0);
        check("R12", "host_rvalid after reset", host_rvalid, 0);
        host_read("R12", 0, 7'h00);
        host_read("R12", NUM_PAGES - 1, 7'h00);
    endtask

    task automatic t_load_clean();
        access("R3", T_LOAD, page_addr(1, 'h34), 3'b111, 1'b1, 3'b101);
        host_read("R5", 1, 7'b0000010);
    endtask

    task automatic t_store();
        access("R4", T_STORE, page_addr(2, 'hFFC), 3'b111, 1'b1, 3'b111);
        host_read("R4", 2, 7'b0000011);
    endtask

    task automatic t_load_changed();
        access("R3", T_LOAD, page_addr(2, 0), 3'b111, 1'b1, 3'b111);
        host_read("R6", 2, 7'b0000011);
    endtask

    task automatic t_fetch();
        access("R3", T_FETCH, page_addr(3, 8), 3'b110, 1'b1, 3'b100);
        host_read("R5", 3, 7'b0000010);
    endtask

    task automatic t_disabled();
        access("R1", T_STORE, page_addr(4, 0), 3'b011, 1'b0, 3'b011);
        access("R1", T_LOAD, page_addr(4, 0), 3'b111, 1'b0, 3'b111);
        host_read("R1", 4, 7'h00);
    endtask

    task automatic t_keep_fields();
        host_write(5, 7'b1011100);
        access("R4", T_STORE, page_addr(5, 0), 3'b111, 1'b1, 3'b111);
        host_read("R5", 5, 7'b1011111);
    endtask

    task automatic t_index();
        access("R2", T_LOAD, page_addr(6, 'hABC), 3'b111, 1'b1, 3'b101);
        host_read("R2", 6, 7'b0000010);
        host_read("R2", 7, 7'h00);
        access("R2", T_STORE, page_addr(6 + NUM_PAGES, 'h10), 3'b111, 1'b1, 3'b111);
        host_read("R2", 6, 7'b0000011);
    endtask

    task automatic t_noop();
        access("R11", T_NONE, page_addr(8, 0), 3'b010, 1'b1, 3'b010);
        host_read("R11", 8, 7'h00);
    endtask

    // Store then load to one page in adjacent cycles.
    task automatic t_forward();
        @(negedge clk); drive_acc(T_STORE, page_addr(10, 0), 3'b111, 1'b1);
        @(posedge clk);
        @(negedge clk); drive_acc(T_LOAD, page_addr(10, 4), 3'b111, 1'b1);
        @(posedge clk);
        @(negedge clk); idle_acc();
        check("R8", "store rsp_valid", rsp_valid, 1);
        check("R8", "store rsp_flags", rsp_flags, 3'b111);
        @(posedge clk);
        @(negedge clk);
        check("R8", "load after store rsp_valid", rsp_valid, 1);
        check("R8", "load after store keeps write", rsp_flags, 3'b111);
        host_read("R8", 10, 7'b0000011);
        // Two loads to a clean page: both lose write permission.
        @(negedge clk); drive_acc(T_LOAD, page_addr(11, 0), 3'b111, 1'b1);
        @(posedge clk);
        @(negedge clk); drive_acc(T_LOAD, page_addr(11, 0), 3'b111, 1'b1);
        @(posedge clk);
        @(negedge clk); idle_acc();
        check("R8", "first load flags", rsp_flags, 3'b101);
        @(posedge clk);
        @(negedge clk);
        check("R8", "second load flags", rsp_flags, 3'b101);
        host_read("R8", 11, 7'b0000010);
    endtask

    // Host write collides with the update write to the same page.
    task automatic t_host_priority();
        @(negedge clk); drive_acc(T_STORE, page_addr(9, 0), 3'b111, 1'b1);
        @(posedge clk);
        @(negedge clk); idle_acc();
        host_valid = 1'b1; host_we = 1'b1; host_page = IDX_W'(9); host_wkey = 7'b0101000;
        @(posedge clk);
        @(negedge clk); host_valid = 1'b0; host_we = 1'b0;
        check("R9", "store rsp_flags during collision", rsp_flags, 3'b111);
        host_read("R9", 9, 7'b0101000);
    endtask

    // Host write and access capture to the same page at one edge.
    task automatic t_host_forward();
        @(negedge clk); drive_acc(T_LOAD, page_addr(12, 0), 3'b111, 1'b1);
        host_valid = 1'b1; host_we = 1'b1; host_page = IDX_W'(12); host_wkey = 7'b0000001;
        @(posedge clk);
        @(negedge clk); idle_acc(); host_valid = 1'b0; host_we = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R9", "load sees same-edge host key", rsp_flags, 3'b111);
        host_read("R9", 12, 7'b0000011);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; keys_en = 1'b0;
        idle_acc();
        host_valid = 1'b0; host_we = 1'b0; host_page = '0; host_wkey = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_load_clean();
        t_store();
        t_load_changed();
        t_fetch();
        t_disabled();
        t_keep_fields();
        t_index();
        t_noop();
        t_forward();
        t_host_priority();
        t_host_forward();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule